// File: doc/BRIEF.md
# SPI Master Burst Engine with Byte FIFOs

This block is a byte-wide SPI master driven through a small register port. Software places outgoing bytes in a transmit FIFO, programs how many bytes the burst clocks in total and how many of them come from the transmit FIFO, picks clock polarity, clock phase and bit order, and then sets a go bit. The engine shifts each byte out on `mosi` while it samples `miso`, stores each received byte in a receive FIFO unless the discard option is on, and raises a transfer-complete flag when the burst ends.

The burst length and the transmit length are separate. Once the transmit length is used up, the engine sends zero bytes for the rest of the burst. This lets a short command be followed by a longer read without filling the FIFO with padding. The SPI bit rate comes from `sclk_tick`, a one-cycle enable from an external divider: each tick moves the serial clock by half a period. Data moves between the engine and the FIFOs as valid/ready streams. The engine takes a transmit byte only when the FIFO presents one, and it stalls with `sclk` idle while transmit bytes are still owed and the FIFO is empty. The register port itself is a plain strobe interface with no back-pressure.

Register port (`reg_addr`): 0 receive data (a read with `reg_rd` pops), 1 transmit data (a write pushes bits 7:0), 2 control, 3 interrupt enable, 4 interrupt status, 5 burst length, 6 transmit length, 7 FIFO levels. Reads are combinational.

Top module: `spi_burst_master`

## Requirements
- R1: After reset every register reads 0, both FIFOs are empty, and `sclk`, `mosi` and `irq` are low.
- R2: A write to address 1 pushes bits 7:0 into the 64-entry transmit FIFO, and pushes into a full FIFO are dropped. Address 7 reads the receive level in bits 6:0 and the transmit level in bits 22:16.
- R3: A read of address 0 returns the oldest received byte in bits 7:0, and asserting `reg_rd` on it pops that byte.
- R4: A burst clocks exactly the programmed burst length (address 5, 24 bits) of bytes, each taking 16 ticks of `sclk_tick`, and `sclk` rests at the polarity bit (control bit 3) whenever no burst is running.
- R5: With the phase bit (control bit 2) at 0, `mosi` is valid before the leading `sclk` edge and is sampled on the leading edge. With the phase bit at 1, `mosi` changes on the leading edge and is sampled on the trailing edge. The leading edge is the one that leaves the idle level.
- R6: Bytes go out and come in MSB first, or LSB first when control bit 6 is set.
- R7: The first N bytes of a burst come from the transmit FIFO, where N is the transmit length (address 6, 24 bits). The remaining bytes are 0x00. While a FIFO byte is owed and the FIFO is empty, the engine waits.
- R8: With control bit 15 set, received bytes are not written to the receive FIFO.
- R9: The go bit (control bit 10) clears itself when the burst ends, and at that point status bit 16 is set. A burst length of 0 completes at once with no `sclk` edges.
- R10: Writing 1 to status bit 16 clears it. `irq` is high exactly while status bit 16 and enable bit 16 (address 3) are both set.
- R11: Control bit 8 empties the transmit FIFO and control bit 9 empties the receive FIFO. Each acts without touching the other FIFO and reads back 0 afterwards.
- R12: A burst starts only while the go bit, the enable bit (control bit 0) and the master bit (control bit 1) are all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 0) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| sclk_tick | input | 1 | Half-period enable from the external divider |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Register reads are combinational, so the bench samples them 1 ns after the falling edge that follows the write. FIFO levels and the status bit are visible one cycle after the strobe that changes them. After the go bit is written, the engine spends one cycle leaving idle, then one load cycle per byte plus 16 ticks per byte. With a tick every second cycle, a burst of n bytes ends within about 35·n + 4 cycles. The bench polls the status bit within a bound of 40·n + 20 reads, and only after that checks the received bytes, the FIFO levels and the idle `sclk`. The serial bytes are rebuilt on the sampling edge that the mode calls for and compared with bytes the bench works out from its own seed.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_LOAD, ENG_SHIFT} eng_state_t;

  localparam logic [2:0] A_RXD   = 3'd0;
  localparam logic [2:0] A_TXD   = 3'd1;
  localparam logic [2:0] A_CTRL  = 3'd2;
  localparam logic [2:0] A_IEN   = 3'd3;
  localparam logic [2:0] A_ISTAT = 3'd4;
  localparam logic [2:0] A_BURST = 3'd5;
  localparam logic [2:0] A_XMIT  = 3'd6;
  localparam logic [2:0] A_LEVEL = 3'd7;

  localparam int B_EN    = 0;
  localparam int B_MST   = 1;
  localparam int B_CPHA  = 2;
  localparam int B_CPOL  = 3;
  localparam int B_LSB   = 6;
  localparam int B_TXRST = 8;
  localparam int B_RXRST = 9;
  localparam int B_GO    = 10;
  localparam int B_DISC  = 15;
  localparam int B_TC    = 16;
  localparam int LVL_RX_POS = 0;
  localparam int LVL_TX_POS = 16;

  localparam logic [31:0] CTRL_MASK = (32'd1 << B_EN) | (32'd1 << B_MST) |
    (32'd1 << B_CPHA) | (32'd1 << B_CPOL) | (32'd1 << B_LSB) | (32'd1 << B_TXRST) |
    (32'd1 << B_RXRST) | (32'd1 << B_GO) | (32'd1 << B_DISC);
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push, pop;

  assign out_valid = (level != '0);
  assign push      = in_valid && (level != LW'(DEPTH)) && !clr;
  assign pop       = out_valid && out_ready && !clr;
  assign out_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      level <= level + LW'(push) - LW'(pop);
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb,
  input  logic             discard,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] xmit_len,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             done,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  eng_state_t       state;
  logic [3:0]       bit_cnt;
  logic             phase, mosi_q;
  logic [7:0]       tx_sr, rx_sr, rx_next, load_byte;
  logic [CNT_W-1:0] rem_burst, rem_tx;
  logic             need_tx, lead, sample_now, drive_now;

  function automatic logic first_bit(input logic [7:0] s, input logic l);
    return l ? s[0] : s[7];
  endfunction

  function automatic logic [7:0] shift_out(input logic [7:0] s, input logic l);
    return l ? {1'b0, s[7:1]} : {s[6:0], 1'b0};
  endfunction

  assign need_tx    = (rem_tx != '0);
  assign load_byte  = need_tx ? tx_data : 8'h00;
  assign tx_ready   = (state == ENG_LOAD) && (rem_burst != '0) && need_tx;
  assign done       = (state == ENG_LOAD) && (rem_burst == '0);
  assign busy       = (state != ENG_IDLE);
  assign lead       = !bit_cnt[0];
  assign sample_now = cpha ? !lead : lead;
  assign drive_now  = cpha ? lead : (!lead && bit_cnt != 4'd15);
  assign rx_next    = sample_now ? (lsb ? {miso, rx_sr[7:1]} : {rx_sr[6:0], miso}) : rx_sr;
  assign sclk       = cpol ^ phase;
  assign mosi       = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE; bit_cnt <= '0; phase <= 1'b0; mosi_q <= 1'b0;
      tx_sr <= '0; rx_sr <= '0; rx_valid <= 1'b0; rx_data <= '0;
      rem_burst <= '0; rem_tx <= '0;
    end else begin
      rx_valid <= 1'b0;
      unique case (state)
        ENG_IDLE: begin
          phase <= 1'b0;
          if (run) begin
            rem_burst <= burst_len;
            rem_tx    <= xmit_len;
            state     <= ENG_LOAD;
          end
        end
        ENG_LOAD: begin
          if (rem_burst == '0) begin
            state <= ENG_IDLE;
          end else if (!need_tx || tx_valid) begin
            if (need_tx) rem_tx <= rem_tx - 1'b1;
            bit_cnt <= '0;
            phase   <= 1'b0;
            state   <= ENG_SHIFT;
            if (!cpha) begin
              mosi_q <= first_bit(load_byte, lsb);
              tx_sr  <= shift_out(load_byte, lsb);
            end else begin
              tx_sr  <= load_byte;
            end
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            phase   <= ~phase;
            bit_cnt <= bit_cnt + 1'b1;
            rx_sr   <= rx_next;
            if (drive_now) begin
              mosi_q <= first_bit(tx_sr, lsb);
              tx_sr  <= shift_out(tx_sr, lsb);
            end
            if (bit_cnt == 4'd15) begin
              rem_burst <= rem_burst - 1'b1;
              rx_valid  <= !discard;
              rx_data   <= rx_next;
              state     <= ENG_LOAD;
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 24,
  localparam int LW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sclk_tick,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  logic [31:0]      ctrl_q;
  logic             ie_tc, is_tc;
  logic [CNT_W-1:0] burst_q, xmit_q;
  logic [LW-1:0]    tx_level, rx_level;
  logic             tx_valid, tx_ready, rx_valid, rx_head_valid;
  logic [7:0]       tx_head, rx_byte, rx_head;
  logic             eng_done, eng_busy, run;
  logic             wr_txd, rd_rxd;

  assign wr_txd = reg_wr && (reg_addr == A_TXD);
  assign rd_rxd = reg_rd && (reg_addr == A_RXD);
  assign run    = ctrl_q[B_GO] && ctrl_q[B_EN] && ctrl_q[B_MST];
  assign irq    = ie_tc && is_tc;

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_q[B_TXRST]),
    .in_valid(wr_txd), .in_data(reg_wdata[7:0]),
    .out_valid(tx_valid), .out_ready(tx_ready), .out_data(tx_head),
    .level(tx_level));

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_q[B_RXRST]),
    .in_valid(rx_valid), .in_data(rx_byte),
    .out_valid(rx_head_valid), .out_ready(rd_rxd), .out_data(rx_head),
    .level(rx_level));

  spi_shift_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(sclk_tick),
    .cpol(ctrl_q[B_CPOL]), .cpha(ctrl_q[B_CPHA]), .lsb(ctrl_q[B_LSB]),
    .discard(ctrl_q[B_DISC]), .burst_len(burst_q), .xmit_len(xmit_q),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_head),
    .rx_valid(rx_valid), .rx_data(rx_byte),
    .done(eng_done), .busy(eng_busy), .sclk(sclk), .mosi(mosi), .miso(miso));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; ie_tc <= 1'b0; is_tc <= 1'b0;
      burst_q <= '0; xmit_q <= '0;
    end else begin
      ctrl_q[B_TXRST] <= 1'b0;
      ctrl_q[B_RXRST] <= 1'b0;
      if (reg_wr) begin
        unique case (reg_addr)
          A_CTRL:  ctrl_q  <= reg_wdata & CTRL_MASK;
          A_IEN:   ie_tc   <= reg_wdata[B_TC];
          A_ISTAT: if (reg_wdata[B_TC]) is_tc <= 1'b0;
          A_BURST: burst_q <= reg_wdata[CNT_W-1:0];
          A_XMIT:  xmit_q  <= reg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (eng_done) begin
        ctrl_q[B_GO] <= 1'b0;
        is_tc        <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_RXD:   reg_rdata = rx_head_valid ? {24'd0, rx_head} : 32'd0;
      A_CTRL:  reg_rdata = ctrl_q;
      A_IEN:   reg_rdata[B_TC] = ie_tc;
      A_ISTAT: reg_rdata[B_TC] = is_tc;
      A_BURST: reg_rdata = 32'(burst_q);
      A_XMIT:  reg_rdata = 32'(xmit_q);
      A_LEVEL: reg_rdata = (32'(tx_level) << LVL_TX_POS) | (32'(rx_level) << LVL_RX_POS);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk #(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk,
  input logic          cpol,
  input logic          busy,
  input logic          done,
  input logic          go,
  input logic          en,
  input logic          mst,
  input logic          is_tc,
  input logic          discard,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));

  a_r8_no_rx_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && discard) |=> (rx_level <= $past(rx_level)));

  a_r9_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !go);

  a_r9_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> is_tc);

  a_r12_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go && en && mst));
endmodule

bind spi_burst_master spi_burst_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cpol(ctrl_q[3]), .busy(eng_busy),
  .done(eng_done), .go(ctrl_q[10]), .en(ctrl_q[0]), .mst(ctrl_q[1]),
  .is_tc(is_tc), .discard(ctrl_q[15]), .tx_level(tx_level), .rx_level(rx_level));

// File: tb/sim_spi_burst_master.sv
module sim_spi_burst_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, sclk_tick = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sclk, mosi, miso, irq;
  int          n_vec = 0, n_bad = 0;
  logic        cap_en = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0, ie_on = 1'b0;
  logic [7:0]  cap_sr = '0;
  logic [7:0]  cap_bytes [64];
  logic [7:0]  exp_tx [64];
  int          cap_bits = 0, cap_idx = 0;
  logic        finished = 1'b0;

  localparam logic [31:0] EN_MST = 32'h3;

  assign miso = mosi;

  spi_burst_master u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_tick(sclk_tick), .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq));

  always #10 clk = ~clk;
  initial forever begin @(negedge clk); sclk_tick = ~sclk_tick; end

  always @(sclk) begin
    if (cap_en) begin
      logic leading;
      leading = (sclk != u_cpol());
      if (cfg_cpha ? !leading : leading) begin
        logic [7:0] nx;
        nx = cfg_lsb ? {mosi, cap_sr[7:1]} : {cap_sr[6:0], mosi};
        cap_sr = nx;
        cap_bits++;
        if (cap_bits == 8) begin
          if (cap_idx < 64) cap_bytes[cap_idx] = nx;
          cap_idx++;
          cap_bits = 0;
        end
      end
    end
  end

  logic cfg_cpol = 1'b0;
  function automatic logic u_cpol();
    return cfg_cpol;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_pop(output logic [31:0] d);
    @(negedge clk); reg_addr = 3'd0; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic run_burst(input logic cpol, input logic cpha, input logic lsb,
                           input logic disc, input int nb, input int nt,
                           input int seed, input logic keep_rx);
    logic [31:0] v, ctl;
    bit          got;
    ctl = EN_MST | (32'(cpha) << 2) | (32'(cpol) << 3) | (32'(lsb) << 6) | (32'(disc) << 15);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb = lsb;
    wr(3'd2, ctl | 32'h300);
    for (int i = 0; i < nt; i++) begin
      exp_tx[i] = 8'((seed * 37 + i * 29 + 5) & 255);
      wr(3'd1, 32'(exp_tx[i]));
    end
    rd(3'd7, v);
    check("R2 tx level", v, 32'(nt) << 16);
    wr(3'd5, 32'(nb));
    wr(3'd6, 32'(nt));
    cap_idx = 0; cap_bits = 0; cap_en = 1'b1;
    wr(3'd2, ctl | 32'h400);
    got = 0;
    for (int k = 0; k < nb * 40 + 20 && !got; k++) begin
      rd(3'd4, v);
      if (v[16]) got = 1;
    end
    cap_en = 1'b0;
    check("R9 completion flag", 32'(got), 32'd1);
    check("R10 irq level", 32'(irq), 32'(ie_on));
    rd(3'd2, v);
    check("R9 go cleared", 32'(v[10]), 32'd0);
    check("R4 sclk idle", 32'(sclk), 32'(cpol));
    check("R4 byte count", 32'(cap_idx), 32'(nb));
    for (int i = 0; i < nb && i < 64; i++) begin
      logic [7:0] e;
      e = (i < nt) ? exp_tx[i] : 8'h00;
      check("R5 R6 R7 serial byte", 32'(cap_bytes[i]), 32'(e));
    end
    rd(3'd7, v);
    check("R8 R3 rx level", v, disc ? 32'd0 : 32'(nb));
    if (!disc && !keep_rx) begin
      for (int i = 0; i < nb; i++) begin
        rd_pop(v);
        check("R3 rx byte", v, (i < nt) ? 32'(exp_tx[i]) : 32'd0);
      end
      rd(3'd7, v);
      check("R3 rx drained", v, 32'd0);
    end
    wr(3'd4, 32'h1_0000);
    rd(3'd4, v);
    check("R10 status w1c", v, 32'd0);
    check("R10 irq low", 32'(irq), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset reg", v, 32'd0);
    end
    check("R1 reset pins", {29'd0, sclk, mosi, irq}, 32'd0);

    for (int m = 0; m < 8; m++)
      for (int n = 1; n <= 3; n += 2)
        run_burst(m[0], m[1], m[2], 1'b0, n, n, m * 4 + n, 1'b0);

    run_burst(1'b0, 1'b0, 1'b0, 1'b0, 5, 2, 11, 1'b0);
    run_burst(1'b1, 1'b0, 1'b1, 1'b0, 4, 0, 12, 1'b0);
    run_burst(1'b0, 1'b1, 1'b0, 1'b1, 3, 3, 13, 1'b0);
    run_burst(1'b1, 1'b1, 1'b0, 1'b0, 64, 64, 14, 1'b0);

    cap_idx = 0;
    run_burst(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 15, 1'b0);

    ie_on = 1'b1;
    wr(3'd3, 32'h1_0000);
    run_burst(1'b0, 1'b1, 1'b1, 1'b0, 2, 2, 16, 1'b1);
    ie_on = 1'b0;
    wr(3'd3, 32'd0);

    for (int i = 0; i < 66; i++) wr(3'd1, 32'(i));
    rd(3'd7, v);
    check("R2 full drop", v, (32'd64 << 16) | 32'd2);
    rd(3'd0, v);
    check("R3 head byte", v, 32'(exp_tx[0]));
    wr(3'd2, EN_MST | 32'h100);
    rd(3'd7, v);
    check("R11 tx reset only", v, 32'd2);
    rd(3'd2, v);
    check("R11 bit self-clear", v, EN_MST);
    wr(3'd2, EN_MST | 32'h200);
    rd(3'd7, v);
    check("R11 rx reset", v, 32'd0);

    wr(3'd1, 32'h5A);
    wr(3'd5, 32'd1);
    wr(3'd6, 32'd1);
    wr(3'd2, 32'h2 | 32'h400);
    repeat (80) @(negedge clk);
    rd(3'd7, v);
    check("R12 no start without enable", v, 32'd1 << 16);
    rd(3'd4, v);
    check("R12 no completion", v, 32'd0);
    rd(3'd2, v);
    check("R12 go held", 32'(v[10]), 32'd1);
    wr(3'd2, 32'h1 | 32'h400);
    repeat (80) @(negedge clk);
    rd(3'd7, v);
    check("R12 no start without master", v, 32'd1 << 16);
    wr(3'd2, 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule